// File: doc/BRIEF.md
# Single-Precision Compare and Condition-Code Unit

This block compares two single-precision floating-point operands against a chosen predicate and stores the one-bit outcome in one of eight condition codes. The codes live in a 32-bit status word. The same block also decides conditional moves. A move can test one of the stored codes for set or clear, or it can test an integer operand for zero or nonzero. The move data is always the first floating-point operand.

A caller presents one operation per clock, qualified by a strobe. A compare updates the status word on the following clock edge. A move decision is combinational in the strobe cycle and reads the codes already stored. A single unordered (NaN) detector feeds every predicate. Each predicate whose code has bit 0 set ORs that detector into its ordered result. A code-conditional move takes its code index from the upper three bits of a 5-bit register-number field.

Top module: `fcmp_ccu`

## Requirements
- R1: Predicate code 1 (UN) yields 1 exactly when either operand is a NaN, i.e. exponent field [30:23] all ones and fraction [22:0] nonzero.
- R2: Code 2 (EQ) yields 1 for ordered equal operands, with +0 equal to -0. Code 3 (UEQ) yields EQ or unordered.
- R3: Codes 4 (OLT, less-than) and 6 (OLE, less-or-equal) are ordered. They give 0 whenever either operand is NaN, and infinities and denormals order normally.
- R4: Codes 5 (ULT) and 7 (ULE) give the OLT/OLE result ORed with unordered.
- R5: Code 0 writes 0 into the selected condition code.
- R6: A compare (op_kind 0, op_valid 1) writes its result into condition code cc_sel on the next rising edge. Code 0 is status bit 23, and code k (1..7) is status bit 24+k. All other codes keep their values.
- R7: A synchronous active-high rst clears the status word. Bits outside {23,25..31} always read 0.
- R8: With op_kind 1, the code index is ft_num[4:2]. mv_en is 1 in the strobe cycle when tf_sel=1 and that code is set, or when tf_sel=0 and that code is clear.
- R9: op_kind 2 raises mv_en when rt_val equals 0. op_kind 3 raises mv_en when rt_val is nonzero. Whenever mv_en is 1, mv_data equals fs_val.
- R10: Without op_valid, mv_en is 0 and the status word holds. Move operations never alter the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | 0 compare, 1 move on code, 2 move if rt zero, 3 move if rt nonzero |
| pred_code | input | 3 | Compare predicate (0 F,1 UN,2 EQ,3 UEQ,4 OLT,5 ULT,6 OLE,7 ULE) |
| cc_sel | input | 3 | Condition code written by a compare |
| ft_num | input | 5 | Register-number field; bits [4:2] index the code a move tests |
| tf_sel | input | 1 | Move sense: 1 move when set, 0 move when clear |
| fs_val | input | 32 | First operand, also the move data |
| ft_val | input | 32 | Second operand |
| rt_val | input | 32 | Integer operand for zero/nonzero moves |
| cc_status | output | 32 | Status word holding the condition codes |
| mv_en | output | 1 | Move enable |
| mv_data | output | 32 | Move data |

## Verification
The bench targets operand pairs where a sign-magnitude comparator goes wrong.

- For +0 against -0, a design comparing raw bits would report inequality and a false less-than.
- For two negative numbers, a design that forgot to reverse the magnitude order would invert every result.
- NaNs of both signs, including ones with only the low fraction bit set, catch a detector that tests only the exponent or the quiet bit. Such a detector would make ordered predicates true on NaN, or unordered ones false.
- Every code index is written and then read back through code-conditional moves. Mixed ft_num low bits expose a move that uses the wrong slice of the register field, and writes to codes 0 and 1 expose an off-by-one around the gap at status bit 24.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [1:0] {
        OP_CMP   = 2'd0,
        OP_MOVCC = 2'd1,
        OP_MOVZ  = 2'd2,
        OP_MOVN  = 2'd3
    } fcc_op_e;

    typedef enum logic [2:0] {
        PR_F   = 3'd0,
        PR_UN  = 3'd1,
        PR_EQ  = 3'd2,
        PR_UEQ = 3'd3,
        PR_OLT = 3'd4,
        PR_ULT = 3'd5,
        PR_OLE = 3'd6,
        PR_ULE = 3'd7
    } fcc_pred_e;

    // per-operand classification
    typedef struct packed {
        logic nan;
        logic zero;
        logic sign;
    } fp_class_t;

    // relation between two operands
    typedef struct packed {
        logic unord;
        logic eq;
        logic lt;
    } fp_rel_t;

    // Predicate evaluation: bits [2:1] pick the ordered relation,
    // bit 0 ORs in the shared unordered flag.
    function automatic logic pred_eval(fp_rel_t r, logic [2:0] code);
        logic base;
        case (code[2:1])
            2'b00:   base = 1'b0;
            2'b01:   base = r.eq;
            2'b10:   base = r.lt;
            default: base = r.lt | r.eq;
        endcase
        return (base & ~r.unord) | (code[0] & r.unord);
    endfunction

    // Status-word bit position of condition code idx
    function automatic int cc_pos(int idx, int pos0, int posn);
        return (idx == 0) ? pos0 : (posn + idx - 1);
    endfunction

    // Mask of status bits occupied by condition codes
    function automatic logic [63:0] cc_mask(int n, int pos0, int posn);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < n; i++) begin
            m[cc_pos(i, pos0, posn)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/fcc_classify.sv
module fcc_classify
    import fcc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EXP_W  = 8
) (
    input  logic [DATA_W-1:0] val,
    output fp_class_t         cls,
    output logic [DATA_W-2:0] mag
);
    localparam int MAN_W = DATA_W - 1 - EXP_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f = val[DATA_W-2 -: EXP_W];
    assign man_f = val[MAN_W-1:0];
    assign mag   = val[DATA_W-2:0];

    always_comb begin
        cls.sign = val[DATA_W-1];
        cls.nan  = (&exp_f) & (|man_f);
        cls.zero = ~|val[DATA_W-2:0];
    end

endmodule

// File: rtl/fcc_relate.sv
module fcc_relate
    import fcc_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  fp_class_t        cls_a,
    input  fp_class_t        cls_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output fp_rel_t          rel
);
    logic both_zero;
    logic mag_eq;
    logic mag_lt;
    logic lt_raw;

    assign both_zero = cls_a.zero & cls_b.zero;
    assign mag_eq    = (mag_a == mag_b);
    assign mag_lt    = (mag_a < mag_b);

    always_comb begin
        if (cls_a.sign != cls_b.sign) begin
            lt_raw = cls_a.sign;
        end else if (cls_a.sign) begin
            lt_raw = ~mag_lt & ~mag_eq;
        end else begin
            lt_raw = mag_lt;
        end
    end

    always_comb begin
        rel.unord = cls_a.nan | cls_b.nan;
        rel.eq    = ~rel.unord & (both_zero | ((cls_a.sign == cls_b.sign) & mag_eq));
        rel.lt    = ~rel.unord & ~both_zero & lt_raw;
    end

    // ordered relations must vanish on NaN input
    always_comb begin
        if (rel.unord) begin
            assert_ordered_clear_R3: assert (!rel.eq && !rel.lt);
        end
        assert_eq_lt_excl_R2: assert (!(rel.eq && rel.lt));
    end

endmodule

// File: rtl/fcc_ccreg.sv
module fcc_ccreg
    import fcc_pkg::*;
#(
    parameter int CC_N   = 8,
    parameter int STAT_W = 32,
    parameter int POS0   = 23,
    parameter int POSN   = 25
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(CC_N)-1:0]  wr_idx,
    input  logic                     wr_val,
    input  logic [$clog2(CC_N)-1:0]  rd_idx,
    output logic                     rd_val,
    output logic [STAT_W-1:0]        status
);
    localparam int IDX_W = $clog2(CC_N);
    localparam logic [STAT_W-1:0] USED = STAT_W'(cc_mask(CC_N, POS0, POSN));

    logic [CC_N-1:0] bits;

    for (genvar g = 0; g < CC_N; g++) begin : g_cc
        always_ff @(posedge clk) begin
            if (rst) begin
                bits[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                bits[g] <= wr_val;
            end
        end
    end

    always_comb begin
        status = '0;
        for (int i = 0; i < CC_N; i++) begin
            status[cc_pos(i, POS0, POSN)] = bits[i];
        end
    end

    assign rd_val = bits[rd_idx];

    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> (status == '0));

    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (rst)
        ((status & ~USED) == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(status));

    assert_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (bits[$past(wr_idx)] == $past(wr_val)));

endmodule

// File: rtl/fcc_movgate.sv
module fcc_movgate
    import fcc_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  fcc_op_e          op,
    input  logic             tf,
    input  logic             cc_bit,
    input  logic [INT_W-1:0] rt,
    output logic             en
);
    logic rt_zero;

    assign rt_zero = ~|rt;

    always_comb begin
        en = 1'b0;
        if (valid) begin
            case (op)
                OP_MOVCC: en = ~(tf ^ cc_bit);
                OP_MOVZ:  en = rt_zero;
                OP_MOVN:  en = ~rt_zero;
                default:  en = 1'b0;
            endcase
        end
    end

    assert_movcc_sense_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && op == OP_MOVCC && tf && !cc_bit) |-> !en);

    assert_movn_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && op == OP_MOVN && rt == '0) |-> !en);

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !valid |-> !en);

endmodule

// File: rtl/fcmp_ccu.sv
module fcmp_ccu
    import fcc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EXP_W  = 8,
    parameter int INT_W  = 32,
    parameter int CC_N   = 8,
    parameter int STAT_W = 32,
    parameter int POS0   = 23,
    parameter int POSN   = 25,
    parameter int FT_W   = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    op_valid,
    input  logic [1:0]              op_kind,
    input  logic [2:0]              pred_code,
    input  logic [$clog2(CC_N)-1:0] cc_sel,
    input  logic [FT_W-1:0]         ft_num,
    input  logic                    tf_sel,
    input  logic [DATA_W-1:0]       fs_val,
    input  logic [DATA_W-1:0]       ft_val,
    input  logic [INT_W-1:0]        rt_val,
    output logic [STAT_W-1:0]       cc_status,
    output logic                    mv_en,
    output logic [DATA_W-1:0]       mv_data
);
    localparam int IDX_W = $clog2(CC_N);
    localparam int MAG_W = DATA_W - 1;

    fcc_op_e          op;
    fp_class_t        cls [2];
    logic [MAG_W-1:0] mag [2];
    logic [DATA_W-1:0] opnd [2];
    fp_rel_t          rel;
    logic             cmp_res;
    logic             cmp_wr;
    logic [IDX_W-1:0] mv_idx;
    logic             mv_cc;
    logic             unused_ft_low;

    assign op      = fcc_op_e'(op_kind);
    assign opnd[0] = fs_val;
    assign opnd[1] = ft_val;

    for (genvar k = 0; k < 2; k++) begin : g_opnd
        fcc_classify #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_cls (
            .val (opnd[k]),
            .cls (cls[k]),
            .mag (mag[k])
        );
    end

    fcc_relate #(.MAG_W(MAG_W)) u_rel (
        .cls_a (cls[0]),
        .cls_b (cls[1]),
        .mag_a (mag[0]),
        .mag_b (mag[1]),
        .rel   (rel)
    );

    assign cmp_res = pred_eval(rel, pred_code);
    assign cmp_wr  = op_valid & (op == OP_CMP);

    // code index for moves sits in the upper bits of the register field
    assign mv_idx        = ft_num[FT_W-1 -: IDX_W];
    assign unused_ft_low = ^ft_num[FT_W-IDX_W-1:0];

    fcc_ccreg #(.CC_N(CC_N), .STAT_W(STAT_W), .POS0(POS0), .POSN(POSN)) u_cc (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cmp_wr),
        .wr_idx (cc_sel),
        .wr_val (cmp_res),
        .rd_idx (mv_idx),
        .rd_val (mv_cc),
        .status (cc_status)
    );

    fcc_movgate #(.INT_W(INT_W)) u_mv (
        .clk    (clk),
        .rst    (rst),
        .valid  (op_valid),
        .op     (op),
        .tf     (tf_sel),
        .cc_bit (mv_cc),
        .rt     (rt_val),
        .en     (mv_en)
    );

    assign mv_data = fs_val;

    assert_movdata_R9: assert property (@(posedge clk) disable iff (rst)
        mv_en |-> (mv_data == fs_val));

    assert_move_keeps_cc_R10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op != OP_CMP) |=> $stable(cc_status));

endmodule

// File: tb/sim_fcmp_ccu.sv
`timescale 1ns/100ps
module sim_fcmp_ccu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [2:0]  pred_code = '0;
    logic [2:0]  cc_sel = '0;
    logic [4:0]  ft_num = '0;
    logic        tf_sel = 1'b0;
    logic [31:0] fs_val = '0;
    logic [31:0] ft_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] cc_status;
    logic        mv_en;
    logic [31:0] mv_data;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    logic [31:0] model = '0;
    string last_tag = "R7";

    always #2.5 clk = ~clk;

    fcmp_ccu u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .pred_code(pred_code), .cc_sel(cc_sel), .ft_num(ft_num),
        .tf_sel(tf_sel), .fs_val(fs_val), .ft_val(ft_val), .rt_val(rt_val),
        .cc_status(cc_status), .mv_en(mv_en), .mv_data(mv_data)
    );

    function automatic bit is_nan(logic [31:0] v);
        return (v[30:23] == 8'hff) && (v[22:0] != 0);
    endfunction

    function automatic longint order_key(logic [31:0] v);
        longint m;
        m = longint'(v[30:0]);
        return v[31] ? -m : m;
    endfunction

    function automatic bit ref_pred(logic [2:0] p, logic [31:0] a, logic [31:0] b);
        longint ka, kb;
        if (is_nan(a) || is_nan(b)) return p inside {3'd1, 3'd3, 3'd5, 3'd7};
        ka = order_key(a);
        kb = order_key(b);
        case (p)
            3'd2, 3'd3: return ka == kb;
            3'd4, 3'd5: return ka < kb;
            3'd6, 3'd7: return ka <= kb;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic int bitpos(int cc);
        return (cc == 0) ? 23 : cc + 24;
    endfunction

    function automatic string pred_tag(logic [2:0] p);
        case (p)
            3'd0:       return "R5";
            3'd1:       return "R1";
            3'd2, 3'd3: return "R2";
            3'd4, 3'd6: return "R3";
            default:    return "R4";
        endcase
    endfunction

    function automatic logic [31:0] pick(int k);
        case (k)
            0:  return 32'h0000_0000;
            1:  return 32'h8000_0000;
            2:  return 32'h3f80_0000;
            3:  return 32'hbf80_0000;
            4:  return 32'h4000_0000;
            5:  return 32'hc000_0000;
            6:  return 32'h7f80_0000;
            7:  return 32'hff80_0000;
            8:  return 32'h7fc0_0000;
            9:  return 32'h7f80_0001;
            10: return 32'hffc0_0001;
            11: return 32'h0000_0001;
            12: return 32'h8000_0001;
            13: return 32'h7f7f_ffff;
            14: return 32'h3f80_0001;
            15: return 32'hbf80_0001;
            default: return $urandom;
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic apply(bit v, logic [1:0] op, logic [2:0] p, logic [2:0] cc,
                         logic [4:0] ftn, bit tf, logic [31:0] a, logic [31:0] b,
                         logic [31:0] rt, string tag);
        bit exp_en;
        bit res;
        @(negedge clk);
        check(cc_status == model, last_tag, "status", cc_status, model);
        op_valid = v; op_kind = op; pred_code = p; cc_sel = cc;
        ft_num = ftn; tf_sel = tf; fs_val = a; ft_val = b; rt_val = rt;
        #1;
        exp_en = 1'b0;
        if (v) begin
            case (op)
                2'd1:    exp_en = tf ? model[bitpos(int'(ftn[4:2]))] : !model[bitpos(int'(ftn[4:2]))];
                2'd2:    exp_en = (rt == 0);
                2'd3:    exp_en = (rt != 0);
                default: exp_en = 1'b0;
            endcase
        end
        check(mv_en == exp_en, tag, "mv_en", {31'd0, mv_en}, {31'd0, exp_en});
        if (exp_en) check(mv_data == a, "R9", "mv_data", mv_data, a);
        if (v && op == 2'd0) begin
            res = ref_pred(p, a, b);
            model[bitpos(int'(cc))] = res;
            last_tag = {"R6/", pred_tag(p)};
        end else begin
            last_tag = v ? "R10" : "R10 idle";
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        check(cc_status == 32'h0, "R7", "status after reset", cc_status, 32'h0);
        last_tag = "R7";
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(cc_status == 32'h0, "R7", "reset state", cc_status, 32'h0);

        // R1 unordered with various NaN encodings
        apply(1, 0, 3'd1, 3'd0, 5'd0, 0, 32'h7f80_0001, 32'h3f80_0000, 0, "R1");
        apply(1, 0, 3'd1, 3'd1, 5'd0, 0, 32'h3f80_0000, 32'hffc0_0001, 0, "R1");
        apply(1, 0, 3'd1, 3'd2, 5'd0, 0, 32'h7f80_0000, 32'hff80_0000, 0, "R1");
        // R2 +0 vs -0 and NaN
        apply(1, 0, 3'd2, 3'd3, 5'd0, 0, 32'h0000_0000, 32'h8000_0000, 0, "R2");
        apply(1, 0, 3'd2, 3'd4, 5'd0, 0, 32'h7fc0_0000, 32'h7fc0_0000, 0, "R2");
        apply(1, 0, 3'd3, 3'd5, 5'd0, 0, 32'h7fc0_0000, 32'h0000_0000, 0, "R2");
        // R3 ordered lt/le including negatives and infinities
        apply(1, 0, 3'd4, 3'd6, 5'd0, 0, 32'hc000_0000, 32'hbf80_0000, 0, "R3");
        apply(1, 0, 3'd4, 3'd7, 5'd0, 0, 32'h8000_0000, 32'h0000_0000, 0, "R3");
        apply(1, 0, 3'd6, 3'd0, 5'd0, 0, 32'hff80_0000, 32'h8000_0001, 0, "R3");
        apply(1, 0, 3'd6, 3'd1, 5'd0, 0, 32'h3f80_0000, 32'h7f80_0001, 0, "R3");
        // R4 unordered-or variants
        apply(1, 0, 3'd5, 3'd2, 5'd0, 0, 32'h4000_0000, 32'h7fc0_0000, 0, "R4");
        apply(1, 0, 3'd7, 3'd3, 5'd0, 0, 32'h4000_0000, 32'h3f80_0000, 0, "R4");
        // R5 false predicate clears a code
        apply(1, 0, 3'd0, 3'd6, 5'd0, 0, 32'h0, 32'h0, 0, "R5");

        // R6 set all codes true then check the mapped word
        for (int i = 0; i < 8; i++)
            apply(1, 0, 3'd2, 3'(i), 5'd0, 0, 32'h3f80_0000, 32'h3f80_0000, 0, "R6");
        @(negedge clk);
        check(cc_status == 32'hfe80_0000, "R6", "all codes set", cc_status, 32'hfe80_0000);
        // clear code 1 only
        apply(1, 0, 3'd0, 3'd1, 5'd0, 0, 0, 0, 0, "R6");
        @(negedge clk);
        check(cc_status == 32'hfc80_0000, "R6", "code1 cleared", cc_status, 32'hfc80_0000);

        // R8 moves on code, index from ft_num[4:2], low bits noise
        for (int i = 0; i < 8; i++) begin
            apply(1, 1, 3'd0, 3'd0, {3'(i), 2'b11}, 1, 32'h1234_5678, 0, 0, "R8");
            apply(1, 1, 3'd0, 3'd0, {3'(i), 2'b01}, 0, 32'h9abc_def0, 0, 0, "R8");
        end
        // R9 zero/nonzero moves
        apply(1, 2, 3'd0, 3'd0, 5'd0, 0, 32'hdead_beef, 0, 32'h0, "R9");
        apply(1, 2, 3'd0, 3'd0, 5'd0, 0, 32'hdead_beef, 0, 32'h8000_0000, "R9");
        apply(1, 3, 3'd0, 3'd0, 5'd0, 0, 32'hcafe_f00d, 0, 32'h0, "R9");
        apply(1, 3, 3'd0, 3'd0, 5'd0, 0, 32'hcafe_f00d, 0, 32'h0000_0001, "R9");
        // R10 idle with compare-looking inputs must not change codes
        apply(0, 0, 3'd0, 3'd7, 5'd0, 0, 0, 0, 0, "R10");
        apply(0, 2, 3'd0, 3'd0, 5'd0, 0, 0, 0, 0, "R10");

        // R7 reset mid-run
        do_reset();

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] op;
            logic [2:0] p;
            op = 2'($urandom);
            p  = 3'($urandom);
            apply(($urandom_range(0, 7) != 0), op, p, 3'($urandom), 5'($urandom),
                  1'($urandom), pick($urandom_range(0, 19)), pick($urandom_range(0, 19)),
                  ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom,
                  (op == 0) ? pred_tag(p) : ((op == 1) ? "R8" : "R9"));
        end
        @(negedge clk);
        check(cc_status == model, last_tag, "final status", cc_status, model);

        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule